// File: doc/BRIEF.md
# Sequential-Sweep Register Memory

This block is a small word memory that is only ever visited in a fixed order. A user such as a filter datapath walks through it one word per step. Each step returns the word at the current position and can overwrite that word. No address is supplied. The current position is held in a thermometer-coded pointer register: it starts all ones, and each step pushes one more zero in at the low end. The single row whose pointer bit is 1 while its lower neighbour is 0 (or, for row 0, has no lower neighbour) is the active row. No binary counter or decoder is involved.

An active-low end-of-sweep flag goes low while the pointer sits on its last pattern. That pattern has only the top bit set. The next step reloads all ones and begins a new sweep. A rotate mode moves the physical row that maps to logical position 0 by one row at each wrap, so a bank of state variables can be aged once per sample period without moving any data. A restart input returns the pointer to the start of a sweep from any position.

The pointer has three named phases. START is the all-ones pattern. MIDDLE covers every pattern that has some low zeros and more than one one. FINAL is the pattern with only the top bit set. There are three transitions. ADVANCE (a step from START or MIDDLE) shifts in a zero. WRAP (a step in FINAL) reloads all ones. RESTART (the restart input, from any phase) reloads all ones.

Top module: `seqmem_ring`

## Requirements
- R1: After reset the pointer is all ones (logical position 0), the start offset maps logical position 0 to physical row 0, every row holds zero, and `last_n` is 1.
- R2: Each step without restart, taken from START or MIDDLE, advances the logical position by one. After k steps the low k pointer bits are 0 and the rest are 1.
- R3: Exactly one physical row is selected in every cycle.
- R4: `last_n` is 0 exactly while the logical position is DEPTH-1, that is, while the pointer has only its top bit set. It is 1 in all other positions.
- R5: A step taken at logical position DEPTH-1 returns the pointer to all ones (logical position 0).
- R6: Restart returns the pointer to all ones from any position. It takes priority over step, suppresses any write in that cycle, and leaves the start offset unchanged.
- R7: `rd_data` shows the word in the selected physical row. When step and `wr_en` are both 1 and restart is 0, `wr_data` is stored into the selected row at the clock edge, and `rd_data` still shows the old word during that cycle.
- R8: When step is 0, `wr_en` has no effect on any row.
- R9: When step and restart are both 0, the pointer and `rd_data` hold their values.
- R10: Logical position L maps to physical row (L + offset) mod DEPTH. The offset is sampled only at a wrap: it increases by one (mod DEPTH) when `rotate_en` is 1 during the wrapping step, and it is kept otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | Perform one access and advance the pointer |
| restart | input | 1 | Return the pointer to the start of the sweep |
| wr_en | input | 1 | Write the selected row during a step |
| wr_data | input | WIDTH | Word to be written |
| rotate_en | input | 1 | Advance the start offset at the next wrap |
| rd_data | output | WIDTH | Word in the currently selected row |
| last_n | output | 1 | Low while the final sweep position is selected |

## Verification
The properties assume that DEPTH is at least 2, so that START and FINAL are different patterns. They also assume that `step`, `restart`, `wr_en` and `rotate_en` are driven to known levels once reset is released. The hold property further assumes that `wr_data` has no influence when step is low. The bench changes its inputs only at falling clock edges and holds every control at a defined 0 or 1 in every cycle. It combines restart with step and write, and it sets `rotate_en` both at wrap and away from wrap, so each priority case is reached with legal inputs.

// File: rtl/seqmem_pkg.sv
package seqmem_pkg;
    typedef enum logic [1:0] {
        PH_START  = 2'd0,
        PH_MIDDLE = 2'd1,
        PH_FINAL  = 2'd2
    } phase_t;
endpackage

// File: rtl/seqmem_therm_ptr.sv
module seqmem_therm_ptr
    import seqmem_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             restart,
    output logic [DEPTH-1:0] ptr,
    output logic             wrap,
    output logic             last_n
);
    localparam logic [DEPTH-1:0] ALL_ONES  = {DEPTH{1'b1}};
    localparam logic [DEPTH-1:0] FINAL_PAT = ALL_ONES << (DEPTH - 1);

    phase_t           phase;
    logic [DEPTH-1:0] ptr_nxt;

    // phase decode of the current pointer pattern
    always_comb begin
        if (ptr == ALL_ONES)       phase = PH_START;
        else if (ptr == FINAL_PAT) phase = PH_FINAL;
        else                       phase = PH_MIDDLE;
    end

    // transitions: ADVANCE, WRAP, RESTART
    always_comb begin
        ptr_nxt = ptr;
        unique case (phase)
            PH_START, PH_MIDDLE: if (step) ptr_nxt = ptr << 1;
            PH_FINAL:            if (step) ptr_nxt = ALL_ONES;
            default:             ptr_nxt = ALL_ONES;
        endcase
        if (restart) ptr_nxt = ALL_ONES;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr <= ALL_ONES;
        else        ptr <= ptr_nxt;
    end

    // outputs
    always_comb begin
        last_n = (phase != PH_FINAL);
        wrap   = step && !restart && (phase == PH_FINAL);
    end
endmodule

// File: rtl/seqmem_offset.sv
module seqmem_offset #(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap,
    input  logic             rotate_en,
    output logic [DEPTH-1:0] base
);
    localparam logic [DEPTH-1:0] BASE_RST = {{(DEPTH-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                base <= BASE_RST;
        else if (wrap && rotate_en) base <= {base[DEPTH-2:0], base[DEPTH-1]};
    end
endmodule

// File: rtl/seqmem_row_sel.sv
module seqmem_row_sel #(
    parameter int DEPTH = 8
) (
    input  logic [DEPTH-1:0] ptr,
    input  logic [DEPTH-1:0] base,
    output logic [DEPTH-1:0] row_sel
);
    logic [DEPTH-1:0] lsel;

    // boundary detect: a row fires where its bit is 1 and the bit below is 0
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_edge
            if (i == 0) begin : g_bottom
                assign lsel[i] = ptr[i];
            end else begin : g_upper
                assign lsel[i] = ptr[i] & ~ptr[i-1];
            end
        end
    endgenerate

    // rotate the logical one-hot by the one-hot start offset
    always_comb begin
        row_sel = '0;
        for (int p = 0; p < DEPTH; p++) begin
            for (int o = 0; o < DEPTH; o++) begin
                row_sel[p] = row_sel[p] | (base[o] & lsel[(p + DEPTH - o) % DEPTH]);
            end
        end
    end
endmodule

// File: rtl/seqmem_store.sv
module seqmem_store #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] row_sel,
    input  logic             wr,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] rows [DEPTH];

    generate
        for (genvar r = 0; r < DEPTH; r++) begin : g_row
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                 rows[r] <= '0;
                else if (wr && row_sel[r])  rows[r] <= wr_data;
            end
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int r = 0; r < DEPTH; r++) begin
            if (row_sel[r]) rd_data = rd_data | rows[r];
        end
    end
endmodule

// File: rtl/seqmem_ring.sv
module seqmem_ring #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             restart,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rotate_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             last_n
);
    logic [DEPTH-1:0] ptr;
    logic [DEPTH-1:0] base;
    logic [DEPTH-1:0] row_sel;
    logic             wrap;
    logic             wr;

    assign wr = step & wr_en & ~restart;

    seqmem_therm_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk(clk), .rst_n(rst_n), .step(step), .restart(restart),
        .ptr(ptr), .wrap(wrap), .last_n(last_n)
    );

    seqmem_offset #(.DEPTH(DEPTH)) u_off (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .rotate_en(rotate_en), .base(base)
    );

    seqmem_row_sel #(.DEPTH(DEPTH)) u_sel (
        .ptr(ptr), .base(base), .row_sel(row_sel)
    );

    seqmem_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk(clk), .rst_n(rst_n), .row_sel(row_sel), .wr(wr),
        .wr_data(wr_data), .rd_data(rd_data)
    );
endmodule

// File: rtl/seqmem_ring_chk.sv
module seqmem_ring_chk #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step,
    input logic             restart,
    input logic [WIDTH-1:0] rd_data,
    input logic             last_n,
    input logic [DEPTH-1:0] ptr,
    input logic [DEPTH-1:0] row_sel
);
    localparam logic [DEPTH-1:0] ALL_ONES = {DEPTH{1'b1}};

    assert_one_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(row_sel) == 1);

    assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !restart && last_n) |=> (ptr == ($past(ptr) << 1)));

    assert_leave_final_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !restart && !last_n) |=> last_n);

    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !restart && !last_n) |=> (ptr == ALL_ONES));

    assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (ptr == ALL_ONES));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !restart) |=> ($stable(ptr) && $stable(rd_data)));
endmodule

bind seqmem_ring seqmem_ring_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .step(step), .restart(restart),
    .rd_data(rd_data), .last_n(last_n), .ptr(ptr), .row_sel(row_sel)
);

// File: tb/seqmem_ring_test.sv
module seqmem_ring_test;
    localparam int CLK_P = 10;
    localparam int D = 8;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         step = 1'b0;
    logic         restart = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rotate_en = 1'b0;
    logic [W-1:0] rd_data;
    logic         last_n;

    int nchecks = 0;
    int nerr = 0;
    bit done = 0;

    logic [W-1:0] expm [D];
    int pos = 0;
    int off = 0;

    seqmem_ring #(.DEPTH(D), .WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .step(step), .restart(restart),
        .wr_en(wr_en), .wr_data(wr_data), .rotate_en(rotate_en),
        .rd_data(rd_data), .last_n(last_n)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic int phys();
        return (pos + off) % D;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] ex);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, ex);
        end
    endtask

    task automatic check_state(input string req);
        chk(rd_data == expm[phys()], req, rd_data, expm[phys()]);
        chk(last_n == ((pos == D-1) ? 1'b0 : 1'b1), "R4 last_n",
            {{(W-1){1'b0}}, last_n}, {{(W-1){1'b0}}, (pos != D-1)});
    endtask

    // one clock: inputs set at the falling edge, results sampled at the next falling edge
    task automatic cyc(input logic st, input logic rs, input logic we,
                       input logic rot, input logic [W-1:0] wd, input string req);
        step = st; restart = rs; wr_en = we; rotate_en = rot; wr_data = wd;
        #1;
        if (st && we && !rs)
            chk(rd_data == expm[phys()], "R7 old word visible during write", rd_data, expm[phys()]);
        @(posedge clk);
        if (rs) pos = 0;
        else if (st) begin
            if (we) expm[phys()] = wd;
            if (pos == D-1) begin
                pos = 0;
                if (rot) off = (off + 1) % D;
            end else pos++;
        end
        @(negedge clk);
        step = 0; restart = 0; wr_en = 0; rotate_en = 0;
        check_state(req);
    endtask

    task automatic t_reset();
        chk(last_n == 1'b1, "R1 last_n after reset", {{(W-1){1'b0}}, last_n}, 16'h1);
        chk(rd_data == '0, "R1 row content after reset", rd_data, '0);
    endtask

    task automatic t_fill();
        for (int i = 0; i < D; i++) cyc(1, 0, 1, 0, W'(16'h1100 + i), "R2 R7 fill sweep");
    endtask

    task automatic t_readback(input string req);
        for (int i = 0; i < D; i++) cyc(1, 0, 0, 0, '0, req);
    endtask

    task automatic t_ignore_write();
        cyc(1, 0, 0, 0, '0, "R2 advance");
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 16'hBEEF, "R8 R9 write without step ignored");
        while (pos != 0) cyc(1, 0, 0, 0, '0, "R5 return to start");
        t_readback("R8 no row changed");
    endtask

    task automatic t_restart();
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, '0, "R2 advance");
        cyc(1, 1, 1, 0, 16'hDEAD, "R6 restart over step and write");
        while (pos != D-1) cyc(1, 0, 0, 0, '0, "R4 approach final");
        cyc(0, 1, 0, 1, '0, "R6 restart from final");
        t_readback("R6 no write during restart");
    endtask

    task automatic t_rotate();
        while (pos != D-1) cyc(1, 0, 0, 1, '0, "R10 rotate ignored away from wrap");
        cyc(1, 0, 0, 1, '0, "R10 wrap with rotate");
        t_readback("R10 R3 rotated mapping");
        cyc(1, 0, 1, 0, 16'h7777, "R10 write at rotated start");
        while (pos != D-1) cyc(1, 0, 0, 0, '0, "R2 advance");
        cyc(1, 0, 0, 0, '0, "R10 wrap without rotate keeps offset");
        t_readback("R10 offset kept");
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", nchecks, nerr);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < D; i++) expm[i] = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_readback("R5 R3 R7 readback after wrap");
        t_ignore_write();
        t_restart();
        t_rotate();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", nchecks, nerr);
        $finish;
    end
endmodule